// File: doc/BRIEF.md
# PTP Transmit Offset Configuration Sequencer

This block brings up the transmit side of a precision-time timestamping core without driver software. After every transmit reset it waits for the core to report that its raw offset measurements are valid. It then acts as a simple memory-mapped register master. It reads three raw values from the core: a constant path delay, an alignment-pulse offset and a wire delay. From these it derives two words and writes them back. The first is a signed timing-alignment correction. The second is a positive extra-latency word, built from the serializer delay (given in unit intervals) and an external PHY delay.

The constant delay and the pulse offset arrive in sign-magnitude form. The alignment correction is the sum of the signed constant delay and the signed pulse offset, minus the wire delay. The serializer delay in nanoseconds is the delay in unit intervals times the unit-interval length. The unit-interval length is a fixed input with 4 integer and 28 fractional nanosecond bits. Their product is rescaled to the common format of integer nanoseconds with 16 fractional bits before the external PHY delay is added. A fixed nominal unit-interval value is used and no drift measurement is done. After both words are written, a configuration-complete flag is set in the core and the block waits for the core's ready status. A transmit reset at any moment restarts the whole flow.

States: `ST_WAIT_VALID` (idle, watching offset-valid), `ST_RD_REQ` (read strobe held until accepted), `ST_RD_DATA` (waiting for the read-data pulse), `ST_WR_REQ` (write strobe held until accepted), `ST_WAIT_READY` (waiting for ready) and `ST_DONE`. The transitions are as follows. Offset-valid moves WAIT_VALID to RD_REQ with slot 0. Acceptance moves RD_REQ to RD_DATA. A read-data pulse moves RD_DATA to RD_REQ of the next slot, or to WR_REQ slot 0 after the third read. Acceptance moves WR_REQ to the next slot, or to WAIT_READY after the third write. Ready moves WAIT_READY to DONE. Reset moves every state to WAIT_VALID.

Top module: `ptp_tx_offset_seq`

## Requirements
- R1: After reset, and until `offset_valid_i` is sampled high, the block issues no read or write and holds `done_o` and `timeout_err_o` low.
- R2: The block makes exactly three reads, in this order: constant delay (`ADDR_CONST`), pulse offset (`ADDR_PULSE`), wire delay (`ADDR_WIRE`). `bus_read_o` and the address stay steady until `bus_waitreq_i` is sampled low. The block then waits for `bus_rdvalid_i` and captures `bus_rdata_i` in that cycle.
- R3: Each write holds `bus_write_o`, the address and the data steady until `bus_waitreq_i` is sampled low.
- R4: The alignment word is the low 32 bits (two's complement) of C + P − W. For C and P, bit 31 set means negative and bits 30:0 give the magnitude. W is bits 19:0 of the wire-delay read, unsigned. Its upper bits are ignored.
- R5: The extra-latency word has bit 31 = 0. Bits 30:0 hold the low 31 bits of ((`pma_delay_ui_i` × `ui_value_i`) >> 12) + `ext_phy_delay_i`. Here `ui_value_i` is 4.28 fixed point and the other values are ns with 16 fractional bits.
- R6: The writes go in this order: extra latency to `ADDR_XLAT`, then the alignment word to `ADDR_ALIGN`, then the value 1 (bit 0 = configuration complete) to `ADDR_CFG`.
- R7: After the third write is accepted, the block waits for `ptp_ready_i`. `done_o` rises in the cycle after ready is sampled and stays high until reset.
- R8: A reset asserted at any point aborts the flow. Once it is released, the block behaves as in R1 and restarts from the first read.
- R9: `timeout_err_o` is set when a wait for offset-valid or for ready has lasted `TIMEOUT_CYC` sampled cycles with the condition low. A condition that is high in the last of those cycles avoids the error. The flag is sticky until reset, and the wait goes on.
- R10: `bus_read_o` and `bus_write_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous transmit reset |
| offset_valid_i | input | 1 | Raw offset data valid status from the core |
| ptp_ready_i | input | 1 | Transmit timestamp path ready status |
| ui_value_i | input | 32 | Unit interval, 4 integer + 28 fractional ns bits |
| pma_delay_ui_i | input | PMA_UI_W | Serializer delay in unit intervals |
| ext_phy_delay_i | input | 31 | External PHY delay, ns with 16 fractional bits |
| bus_addr_o | output | ADDR_W | Register address |
| bus_read_o | output | 1 | Read request |
| bus_write_o | output | 1 | Write request |
| bus_wdata_o | output | 32 | Write data |
| bus_waitreq_i | input | 1 | Request not yet accepted |
| bus_rdata_i | input | 32 | Read data |
| bus_rdvalid_i | input | 1 | Read data valid pulse |
| done_o | output | 1 | Bring-up complete |
| timeout_err_o | output | 1 | Sticky wait-timeout flag |

## Verification
Two functions can fall on the same clock edge: the last cycle of the timeout window and the arrival of the awaited status. The bench counts cycles from the acceptance of the configuration-complete write. It raises ready so that ready is sampled exactly on the edge where the window closes, and expects no error. In a second run it raises ready one cycle later and expects the sticky flag. A behavioural model that tracks the wait counter predicts `timeout_err_o` and `done_o` on every clock, and the bench compares both ports against it, so the edge ordering is judged cycle by cycle.

// File: rtl/ptp_txcfg_pkg.sv
package ptp_txcfg_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_VALID,
        ST_RD_REQ,
        ST_RD_DATA,
        ST_WR_REQ,
        ST_WAIT_READY,
        ST_DONE
    } seq_state_e;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned NUM_XFER  = 3;
    localparam int unsigned IDX_W     = 2;
    localparam int unsigned SUM_W     = 34;
    localparam logic [REG_W-1:0] CFG_DONE_WORD = 32'h0000_0001;

    // Sign-magnitude (bit 31 sign, 30:0 magnitude) to wide signed value.
    function automatic logic signed [SUM_W-1:0] sm_to_signed(input logic [REG_W-1:0] raw);
        logic signed [SUM_W-1:0] mag;
        mag = $signed({{(SUM_W-REG_W+1){1'b0}}, raw[REG_W-2:0]});
        return raw[REG_W-1] ? -mag : mag;
    endfunction

endpackage

// File: rtl/ptp_offset_calc.sv
module ptp_offset_calc
    import ptp_txcfg_pkg::*;
#(
    parameter int unsigned WIRE_W   = 20,
    parameter int unsigned PMA_UI_W = 16,
    parameter int unsigned UI_FRAC  = 28,
    parameter int unsigned NS_FRAC  = 16
) (
    input  logic [REG_W-1:0]    const_raw_i,
    input  logic [REG_W-1:0]    pulse_raw_i,
    input  logic [REG_W-1:0]    wire_raw_i,
    input  logic [REG_W-1:0]    ui_value_i,
    input  logic [PMA_UI_W-1:0] pma_ui_i,
    input  logic [REG_W-2:0]    ext_delay_i,
    output logic [REG_W-1:0]    align_o,
    output logic [REG_W-1:0]    xlat_o
);
    localparam int unsigned SHIFT  = UI_FRAC - NS_FRAC;
    localparam int unsigned PROD_W = PMA_UI_W + REG_W;

    logic signed [SUM_W-1:0] wire_s;
    logic signed [SUM_W-1:0] acc;
    logic [PROD_W-1:0]       prod;
    logic [PROD_W-1:0]       prod_ns;
    logic [REG_W-2:0]        lat_sum;

    always_comb begin
        wire_s  = $signed({{(SUM_W-WIRE_W){1'b0}}, WIRE_W'(wire_raw_i)});
        acc     = sm_to_signed(const_raw_i) + sm_to_signed(pulse_raw_i) - wire_s;
        align_o = REG_W'(acc);
        prod    = PROD_W'(pma_ui_i) * PROD_W'(ui_value_i);
        prod_ns = prod >> SHIFT;
        lat_sum = (REG_W-1)'(prod_ns) + ext_delay_i;
        xlat_o  = {1'b0, lat_sum};
    end
endmodule

// File: rtl/ptp_wait_timer.sv
module ptp_wait_timer #(
    parameter int unsigned TIMEOUT_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic waiting_i,
    input  logic met_i,
    output logic expired_o
);
    localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            expired_o <= 1'b0;
        end else begin
            if (!waiting_i) begin
                cnt_q <= '0;
            end else if (cnt_q != LAST) begin
                cnt_q <= cnt_q + CW'(1);
            end
            if (waiting_i && !met_i && cnt_q == LAST) begin
                expired_o <= 1'b1;
            end
        end
    end

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |=> expired_o);

    assert_no_err_outside_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!expired_o && !waiting_i) |=> !expired_o);
endmodule

// File: rtl/ptp_tx_offset_seq.sv
module ptp_tx_offset_seq
    import ptp_txcfg_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned PMA_UI_W    = 16,
    parameter int unsigned WIRE_W      = 20,
    parameter int unsigned UI_FRAC     = 28,
    parameter int unsigned NS_FRAC     = 16,
    parameter int unsigned TIMEOUT_CYC = 1024,
    parameter logic [ADDR_W-1:0] ADDR_CONST = 8'h10,
    parameter logic [ADDR_W-1:0] ADDR_PULSE = 8'h14,
    parameter logic [ADDR_W-1:0] ADDR_WIRE  = 8'h18,
    parameter logic [ADDR_W-1:0] ADDR_XLAT  = 8'h20,
    parameter logic [ADDR_W-1:0] ADDR_ALIGN = 8'h24,
    parameter logic [ADDR_W-1:0] ADDR_CFG   = 8'h28
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 offset_valid_i,
    input  logic                 ptp_ready_i,
    input  logic [31:0]          ui_value_i,
    input  logic [PMA_UI_W-1:0]  pma_delay_ui_i,
    input  logic [30:0]          ext_phy_delay_i,
    output logic [ADDR_W-1:0]    bus_addr_o,
    output logic                 bus_read_o,
    output logic                 bus_write_o,
    output logic [31:0]          bus_wdata_o,
    input  logic                 bus_waitreq_i,
    input  logic [31:0]          bus_rdata_i,
    input  logic                 bus_rdvalid_i,
    output logic                 done_o,
    output logic                 timeout_err_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_XFER - 1);

    seq_state_e                      state_q, state_d;
    logic [IDX_W-1:0]                idx_q, idx_d;
    logic [NUM_XFER-1:0][REG_W-1:0]  cap_q;
    logic [REG_W-1:0]                align_w, xlat_w;
    logic                            waiting, met;

    // State register and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_VALID;
            idx_q   <= '0;
            cap_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (state_q == ST_RD_DATA && bus_rdvalid_i) begin
                for (int i = 0; i < NUM_XFER; i++) begin
                    if (idx_q == IDX_W'(i)) cap_q[i] <= bus_rdata_i;
                end
            end
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_WAIT_VALID: begin
                if (offset_valid_i) begin
                    state_d = ST_RD_REQ;
                    idx_d   = '0;
                end
            end
            ST_RD_REQ: begin
                if (!bus_waitreq_i) state_d = ST_RD_DATA;
            end
            ST_RD_DATA: begin
                if (bus_rdvalid_i) begin
                    if (idx_q == LAST_IDX) begin
                        state_d = ST_WR_REQ;
                        idx_d   = '0;
                    end else begin
                        state_d = ST_RD_REQ;
                        idx_d   = idx_q + IDX_W'(1);
                    end
                end
            end
            ST_WR_REQ: begin
                if (!bus_waitreq_i) begin
                    if (idx_q == LAST_IDX) state_d = ST_WAIT_READY;
                    else                   idx_d   = idx_q + IDX_W'(1);
                end
            end
            ST_WAIT_READY: begin
                if (ptp_ready_i) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_DONE;
        endcase
    end

    // Outputs
    always_comb begin
        bus_read_o  = 1'b0;
        bus_write_o = 1'b0;
        bus_addr_o  = '0;
        bus_wdata_o = '0;
        done_o      = 1'b0;
        unique case (state_q)
            ST_RD_REQ: begin
                bus_read_o = 1'b1;
                case (idx_q)
                    2'd0:    bus_addr_o = ADDR_CONST;
                    2'd1:    bus_addr_o = ADDR_PULSE;
                    default: bus_addr_o = ADDR_WIRE;
                endcase
            end
            ST_WR_REQ: begin
                bus_write_o = 1'b1;
                case (idx_q)
                    2'd0: begin
                        bus_addr_o  = ADDR_XLAT;
                        bus_wdata_o = xlat_w;
                    end
                    2'd1: begin
                        bus_addr_o  = ADDR_ALIGN;
                        bus_wdata_o = align_w;
                    end
                    default: begin
                        bus_addr_o  = ADDR_CFG;
                        bus_wdata_o = CFG_DONE_WORD;
                    end
                endcase
            end
            ST_DONE: done_o = 1'b1;
            ST_WAIT_VALID, ST_RD_DATA, ST_WAIT_READY: ;
        endcase
    end

    assign waiting = (state_q == ST_WAIT_VALID) || (state_q == ST_WAIT_READY);
    assign met     = (state_q == ST_WAIT_VALID) ? offset_valid_i : ptp_ready_i;

    ptp_offset_calc #(
        .WIRE_W  (WIRE_W),
        .PMA_UI_W(PMA_UI_W),
        .UI_FRAC (UI_FRAC),
        .NS_FRAC (NS_FRAC)
    ) u_calc (
        .const_raw_i(cap_q[0]),
        .pulse_raw_i(cap_q[1]),
        .wire_raw_i (cap_q[2]),
        .ui_value_i (ui_value_i),
        .pma_ui_i   (pma_delay_ui_i),
        .ext_delay_i(ext_phy_delay_i),
        .align_o    (align_w),
        .xlat_o     (xlat_w)
    );

    ptp_wait_timer #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .waiting_i(waiting),
        .met_i    (met),
        .expired_o(timeout_err_o)
    );

    assert_idle_until_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_VALID && !offset_valid_i) |=> (!bus_read_o && !bus_write_o));

    assert_read_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_read_o && bus_waitreq_i) |=> (bus_read_o && $stable(bus_addr_o)));

    assert_write_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_write_o && bus_waitreq_i) |=>
            (bus_write_o && $stable(bus_addr_o) && $stable(bus_wdata_o)));

    assert_ready_to_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_READY && ptp_ready_i) |=> done_o);

    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);

    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_read_o && bus_write_o));
endmodule

// File: tb/tb_ptp_tx_offset_seq.sv
`timescale 1ns/1ps
module tb_ptp_tx_offset_seq;
    localparam int TO = 20;
    localparam logic [7:0] A_CONST = 8'h10, A_PULSE = 8'h14, A_WIRE = 8'h18;
    localparam logic [7:0] A_XLAT  = 8'h20, A_ALIGN = 8'h24, A_CFG  = 8'h28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        offset_valid = 1'b0, ptp_ready = 1'b0;
    logic [31:0] ui_val = 32'h0CCC_CCCD;
    logic [15:0] pma_ui = 16'd100;
    logic [30:0] ext_dly = 31'd360448;
    logic [7:0]  bus_addr;
    logic        bus_read, bus_write;
    logic [31:0] bus_wdata;
    logic        bus_waitreq = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        bus_rdvalid = 1'b0;
    logic        done, terr;

    int n_checks = 0, n_errors = 0;

    always #2 clk = ~clk;

    ptp_tx_offset_seq #(
        .ADDR_W(8), .PMA_UI_W(16), .WIRE_W(20), .UI_FRAC(28), .NS_FRAC(16),
        .TIMEOUT_CYC(TO),
        .ADDR_CONST(A_CONST), .ADDR_PULSE(A_PULSE), .ADDR_WIRE(A_WIRE),
        .ADDR_XLAT(A_XLAT), .ADDR_ALIGN(A_ALIGN), .ADDR_CFG(A_CFG)
    ) dut (
        .clk(clk), .rst_n(rst_n), .offset_valid_i(offset_valid), .ptp_ready_i(ptp_ready),
        .ui_value_i(ui_val), .pma_delay_ui_i(pma_ui), .ext_phy_delay_i(ext_dly),
        .bus_addr_o(bus_addr), .bus_read_o(bus_read), .bus_write_o(bus_write),
        .bus_wdata_o(bus_wdata), .bus_waitreq_i(bus_waitreq), .bus_rdata_i(bus_rdata),
        .bus_rdvalid_i(bus_rdvalid), .done_o(done), .timeout_err_o(terr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected values from the requirements
    function automatic logic [31:0] exp_align(input logic [31:0] c, p, w);
        longint a, b, t;
        a = longint'(c[30:0]); if (c[31]) a = -a;
        b = longint'(p[30:0]); if (p[31]) b = -b;
        t = a + b - longint'(w[19:0]);
        return t[31:0];
    endfunction

    function automatic logic [31:0] exp_xlat();
        longint unsigned pr, s;
        pr = longint'(pma_ui) * longint'(ui_val);
        s  = (pr >> 12) + longint'(ext_dly);
        return {1'b0, s[30:0]};
    endfunction

    // Register-slave model
    logic [31:0] mem_const, mem_pulse, mem_wire;
    int stall = 0, rd_lat = 1, req_age = 0, rd_cnt = 0, wr_count = 0, rd_count = 0;
    logic [7:0]  rd_addr_q = '0;
    logic [7:0]  wlog_a [8];
    logic [31:0] wlog_d [8];
    logic [7:0]  rlog_a [8];

    always @(posedge clk) begin
        if (!rst_n) begin
            req_age = 0;
            rd_cnt  = 0;
        end else begin
            if (rd_cnt > 0) rd_cnt--;
            if (bus_read && !bus_waitreq) begin
                rd_cnt = rd_lat;
                rd_addr_q = bus_addr;
                if (rd_count < 8) rlog_a[rd_count] = bus_addr;
                rd_count++;
            end
            if (bus_write && !bus_waitreq) begin
                if (wr_count < 8) begin
                    wlog_a[wr_count] = bus_addr;
                    wlog_d[wr_count] = bus_wdata;
                end
                wr_count++;
            end
            if ((bus_read || bus_write) && !bus_waitreq) req_age = 0;
            else if (bus_read || bus_write)             req_age++;
            else                                         req_age = 0;
        end
        #1;
        bus_waitreq = rst_n && (bus_read || bus_write) && (req_age < stall);
        bus_rdvalid = rst_n && (rd_cnt == 1);
        case (rd_addr_q)
            A_CONST: bus_rdata = mem_const;
            A_PULSE: bus_rdata = mem_pulse;
            A_WIRE:  bus_rdata = mem_wire;
            default: bus_rdata = 32'hDEAD_BEEF;
        endcase
    end

    // Cycle reference model: 0 idle, 1 read req, 2 read data, 3 write, 4 wait ready, 5 done
    int m_phase = 0, m_idx = 0, m_wcnt = 0;
    bit m_err = 0;
    logic [31:0] m_cap [3];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_idx = 0; m_wcnt = 0; m_err = 0;
        end else begin
            if (m_phase == 0 || m_phase == 4) begin
                if (!(m_phase == 0 ? offset_valid : ptp_ready) && m_wcnt == TO - 1) m_err = 1;
                if (m_wcnt < TO - 1) m_wcnt++;
            end else begin
                m_wcnt = 0;
            end
            case (m_phase)
                0: if (offset_valid) begin m_phase = 1; m_idx = 0; end
                1: if (!bus_waitreq) m_phase = 2;
                2: if (bus_rdvalid) begin
                       m_cap[m_idx] = bus_rdata;
                       if (m_idx == 2) begin m_phase = 3; m_idx = 0; end
                       else begin m_idx++; m_phase = 1; end
                   end
                3: if (!bus_waitreq) begin
                       if (m_idx == 2) m_phase = 4; else m_idx++;
                   end
                4: if (ptp_ready) m_phase = 5;
                default: ;
            endcase
        end
    end

    always @(negedge clk) begin
        bit er, ew;
        logic [7:0] ea;
        er = (m_phase == 1);
        ew = (m_phase == 3);
        check(bus_read == er, "R2", "read strobe", bus_read, er);
        check(bus_write == ew, "R3", "write strobe", bus_write, ew);
        check(!(bus_read && bus_write), "R10", "both strobes", {bus_read, bus_write}, 0);
        if (er) begin
            ea = (m_idx == 0) ? A_CONST : (m_idx == 1) ? A_PULSE : A_WIRE;
            check(bus_addr == ea, "R2", "read addr", bus_addr, ea);
        end
        if (ew) begin
            ea = (m_idx == 0) ? A_XLAT : (m_idx == 1) ? A_ALIGN : A_CFG;
            check(bus_addr == ea, "R6", "write addr", bus_addr, ea);
            if (m_idx == 0)
                check(bus_wdata == exp_xlat(), "R5", "xlat data", bus_wdata, exp_xlat());
            else if (m_idx == 1)
                check(bus_wdata == exp_align(m_cap[0], m_cap[1], m_cap[2]), "R4", "align data",
                      bus_wdata, exp_align(m_cap[0], m_cap[1], m_cap[2]));
            else
                check(bus_wdata == 32'h1, "R6", "cfg data", bus_wdata, 1);
        end
        check(done == (m_phase == 5), "R7", "done", done, m_phase == 5);
        check(terr == m_err, "R9", "timeout flag", terr, m_err);
    end

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; offset_valid = 1'b0; ptp_ready = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic run_flow(input logic [31:0] c, p, w, input int st, lt, rdly, input bit exp_err);
        mem_const = c; mem_pulse = p; mem_wire = w;
        stall = st; rd_lat = lt; wr_count = 0; rd_count = 0;
        @(posedge clk); #1 offset_valid = 1'b1;
        wait (wr_count == 3);
        repeat (rdly) @(posedge clk);
        #1 ptp_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        check(done == 1'b1, "R7", "done after ready", done, 1);
        check(terr == exp_err, "R9", "flag after ready wait", terr, exp_err);
        check(rd_count == 3, "R2", "read count", rd_count, 3);
        check(rlog_a[0] == A_CONST && rlog_a[1] == A_PULSE && rlog_a[2] == A_WIRE,
              "R2", "read order", {rlog_a[0], rlog_a[1], rlog_a[2]}, {A_CONST, A_PULSE, A_WIRE});
        check(wlog_a[0] == A_XLAT && wlog_a[1] == A_ALIGN && wlog_a[2] == A_CFG,
              "R6", "write order", {wlog_a[0], wlog_a[1], wlog_a[2]}, {A_XLAT, A_ALIGN, A_CFG});
        check(wlog_d[0] == exp_xlat(), "R5", "xlat word", wlog_d[0], exp_xlat());
        check(wlog_d[1] == exp_align(c, p, w), "R4", "align word", wlog_d[1], exp_align(c, p, w));
        check(wlog_d[2] == 32'h1, "R6", "cfg word", wlog_d[2], 1);
        repeat (3) @(negedge clk);
        check(done == 1'b1, "R7", "done held", done, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!bus_read && !bus_write && !done && !terr, "R1", "reset state",
              {bus_read, bus_write, done, terr}, 0);
        repeat (5) @(negedge clk);
        check(!bus_read && !bus_write, "R1", "idle without valid", {bus_read, bus_write}, 0);

        // Positive constant, negative pulse offset, no stalls
        run_flow(32'h0001_2345, 32'h8000_4000, 32'h0000_0321, 0, 1, 3, 1'b0);
        do_reset();
        @(negedge clk);
        check(!done && !terr, "R8", "cleared by reset", {done, terr}, 0);

        // Ready sampled exactly at the window close: no error (R9 boundary)
        run_flow(32'h8010_0000, 32'h0002_0000, 32'hABCF_FFFF, 2, 3, TO - 1, 1'b0);
        do_reset();

        // Ready one cycle late: error; magnitudes at their limit
        pma_ui = 16'd7; ui_val = 32'h1000_0000; ext_dly = 31'h7FFF_FFF0;
        run_flow(32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0000_0000, 1, 2, TO, 1'b1);
        do_reset();
        @(negedge clk);
        check(terr == 1'b0, "R9", "flag cleared by reset", terr, 0);

        // Timeout while waiting for valid, then flow completes, flag sticky
        repeat (TO + 3) @(negedge clk);
        check(terr == 1'b1, "R9", "valid wait timeout", terr, 1);
        check(!bus_read, "R1", "no read before valid", bus_read, 0);
        run_flow(32'h8000_0001, 32'h8000_0002, 32'h000F_FFFF, 0, 2, 0, 1'b1);
        do_reset();

        // Reset in the middle of the reads, then full restart
        mem_const = 32'h0000_0100; mem_pulse = 32'h0000_0200; mem_wire = 32'h0000_0050;
        stall = 3; rd_lat = 2;
        @(posedge clk); #1 offset_valid = 1'b1;
        repeat (8) @(posedge clk);
        do_reset();
        @(negedge clk);
        check(!bus_read && !bus_write && !done, "R8", "idle after mid reset",
              {bus_read, bus_write, done}, 0);
        run_flow(32'h0000_0100, 32'h0000_0200, 32'h0000_0050, 3, 2, 2, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule